// File: doc/BRIEF.md
# Station Address Filter Loaded From a Setup Frame

This block decides, one lookup at a time, whether a received Ethernet frame is taken in, judging only by its 48-bit destination address. It keeps a small table of unicast station addresses. Software fills that table by streaming a 192-byte setup frame into the block one byte per beat. The frame is read as 16 slots of 12 bytes. Each slot yields one candidate address. Candidates that are group addresses are dropped, and the remaining ones are packed into the table in the order they arrive.

A lookup strobe carries a destination address. The verdict comes back one cycle later as a single-cycle valid pulse with an accept flag. With the promiscuous input high, every frame is taken. Group-addressed destinations (multicast and broadcast) are always taken. Any other destination is taken only when it equals one of the table entries. A lookup that arrives while a setup frame is being streamed is held back. It is judged against the newly loaded table once the last byte is in.

Top module: `setup_addr_filter`

## Requirements
- R1: After reset the table holds no entries and `res_valid` is low, so a lookup of a unicast destination is rejected while a group destination is accepted.
- R2: Within a 12-byte slot, the candidate address is built from the slot bytes at offsets 0, 1, 4, 5, 8 and 9, in that order. The byte at offset 0 becomes address bits [47:40] and the byte at offset 9 becomes bits [7:0]. Bytes at offsets 2, 3, 6, 7, 10 and 11 have no effect.
- R3: A slot whose candidate has bit 0 of its first byte set (address bit 40) is not stored. Unicast candidates fill the table in order, so with one entry per slot at most 16 entries exist, and every stored one can be matched.
- R4: A `ld_start` pulse discards every table entry and begins a new 192-byte load. This also applies when a load is already in progress.
- R5: When `promisc` is high at the time a lookup is judged, the result is accept.
- R6: A destination with address bit 40 set (group address) is accepted.
- R7: A unicast destination is accepted only when it exactly equals a stored entry. A destination differing in any bit from all entries is rejected.
- R8: A lookup strobe while no load is in progress gives `res_valid` high for exactly one cycle, in the cycle after the strobe.
- R9: A lookup strobe during a load is held. It is judged in the first cycle after the last byte of the load, against the completed table, and its result is valid one cycle after that. A newer strobe replaces a held one.
- R10: Bytes offered with `ld_valid` while no load is in progress, or in the cycle of `ld_start`, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_start | input | 1 | Begin a new setup-frame load; clears the table |
| ld_valid | input | 1 | A setup-frame byte is present on `ld_byte` |
| ld_byte | input | 8 | Setup-frame byte, in frame order |
| lk_req | input | 1 | Lookup strobe |
| lk_addr | input | 48 | Destination address for the lookup; first wire byte in bits [47:40] |
| promisc | input | 1 | Accept every frame |
| res_valid | output | 1 | Lookup verdict present, one cycle |
| res_accept | output | 1 | Verdict: 1 accept, 0 reject |

## Verification
A lookup issued while the block is idle has its verdict registered at the next edge. It is therefore due in the cycle after the strobe. A held lookup is due two cycles after the edge that takes the final setup byte: one cycle to issue, one to register. The bench samples outputs on the falling edge. Its behavioural model steps once per rising edge and predicts `res_valid` and `res_accept` for every cycle, so an early, late or doubled pulse is caught. The directed checks read the verdict on the falling edge that follows the strobe. For the held case, they read one falling edge after the last byte, where the pulse must be absent, and again one falling edge later, where it must be present.

// File: rtl/saf_pkg.sv
package saf_pkg;
  localparam int MAC_BYTES = 6;
  localparam int MAC_W     = 8 * MAC_BYTES;
  localparam int GROUP_BIT = MAC_W - 8;   // bit 0 of the first wire byte

  typedef logic [MAC_W-1:0] mac_t;

  // Slot offset that feeds address lane l: pairs of bytes every 4 bytes.
  function automatic int lane_off(input int l);
    return (l / 2) * 4 + (l % 2);
  endfunction
endpackage

// File: rtl/saf_frame_parser.sv
module saf_frame_parser
  import saf_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int SLOT_BYTES = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_start,
  input  logic       ld_valid,
  input  logic [7:0] ld_byte,
  output logic       loading,
  output logic       wr_en,
  output mac_t       wr_mac
);
  localparam int OFF_W     = $clog2(SLOT_BYTES);
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int FINAL_OFF = lane_off(MAC_BYTES - 1);

  logic [OFF_W-1:0]  off_q, off_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              loading_q, loading_d;
  logic              take, slot_end, frame_end;
  logic [7:0]        stg_q [MAC_BYTES-1];

  assign take      = loading_q & ld_valid & ~ld_start;
  assign slot_end  = (off_q == OFF_W'(SLOT_BYTES - 1));
  assign frame_end = take & slot_end & (slot_q == SLOT_W'(NUM_SLOTS - 1));

  always_comb begin
    off_d     = off_q;
    slot_d    = slot_q;
    loading_d = loading_q;
    if (ld_start) begin
      loading_d = 1'b1;
      off_d     = '0;
      slot_d    = '0;
    end else if (take) begin
      if (slot_end) begin
        off_d  = '0;
        slot_d = slot_q + SLOT_W'(1);
      end else begin
        off_d  = off_q + OFF_W'(1);
      end
      if (frame_end) loading_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q     <= '0;
      slot_q    <= '0;
      loading_q <= 1'b0;
    end else begin
      off_q     <= off_d;
      slot_q    <= slot_d;
      loading_q <= loading_d;
    end
  end

  // Staging for the first five address lanes; the sixth comes straight from the byte input.
  for (genvar l = 0; l < MAC_BYTES - 1; l++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     stg_q[l] <= '0;
      else if (take && off_q == OFF_W'(lane_off(l)))  stg_q[l] <= ld_byte;
    end
    assign wr_mac[MAC_W-1-8*l -: 8] = stg_q[l];
  end
  assign wr_mac[7:0] = ld_byte;

  assign wr_en   = take & (off_q == OFF_W'(FINAL_OFF)) & ~stg_q[0][0];
  assign loading = loading_q;

  // R10: nothing is written while no load is running
  p_idle_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !loading_q |-> !wr_en);
endmodule

// File: rtl/saf_addr_table.sv
module saf_addr_table
  import saf_pkg::*;
#(
  parameter int NUM_SLOTS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr_en,
  input  mac_t wr_mac,
  input  mac_t lk_mac,
  output logic hit
);
  localparam int CNT_W = $clog2(NUM_SLOTS + 1);

  logic [CNT_W-1:0]     count_q, count_d;
  mac_t                 ent_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] hit_vec;

  always_comb begin
    count_d = count_q;
    if (clr)        count_d = '0;
    else if (wr_en) count_d = count_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_ent
    // Entry storage carries no reset; the count decides validity.
    always_ff @(posedge clk) begin
      if (wr_en && count_q == CNT_W'(i)) ent_q[i] <= wr_mac;
    end
    assign hit_vec[i] = (CNT_W'(i) < count_q) && (ent_q[i] == lk_mac);
  end

  assign hit = |hit_vec;

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(NUM_SLOTS));
  p_unicast_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !wr_mac[GROUP_BIT]);
  p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count_q == '0));
endmodule

// File: rtl/saf_lookup_ctrl.sv
module saf_lookup_ctrl
  import saf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic loading,
  input  logic lk_req,
  input  mac_t lk_addr,
  input  logic promisc,
  input  logic hit,
  output mac_t cmp_mac,
  output logic res_valid,
  output logic res_accept
);
  logic pend_q, pend_d;
  mac_t pend_mac_q, pend_mac_d;
  logic valid_q, valid_d, acc_q, acc_d;
  logic issue;

  assign issue   = ~loading & (lk_req | pend_q);
  assign cmp_mac = lk_req ? lk_addr : pend_mac_q;

  always_comb begin
    pend_d     = pend_q;
    pend_mac_d = pend_mac_q;
    if (loading && lk_req) begin
      pend_d     = 1'b1;
      pend_mac_d = lk_addr;
    end else if (issue) begin
      pend_d     = 1'b0;
    end
    valid_d = issue;
    acc_d   = issue & (promisc | cmp_mac[GROUP_BIT] | hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_mac_q <= '0;
      valid_q    <= 1'b0;
      acc_q      <= 1'b0;
    end else begin
      pend_q     <= pend_d;
      pend_mac_q <= pend_mac_d;
      valid_q    <= valid_d;
      acc_q      <= acc_d;
    end
  end

  assign res_valid  = valid_q;
  assign res_accept = acc_q;

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loading |=> !res_valid);
  p_idle_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!loading && lk_req) |=> res_valid);
  p_promisc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && promisc) |=> (res_valid && res_accept));
  p_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && cmp_mac[GROUP_BIT]) |=> res_accept);
endmodule

// File: rtl/setup_addr_filter.sv
module setup_addr_filter
  import saf_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int SLOT_BYTES = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_start,
  input  logic        ld_valid,
  input  logic [7:0]  ld_byte,
  input  logic        lk_req,
  input  logic [47:0] lk_addr,
  input  logic        promisc,
  output logic        res_valid,
  output logic        res_accept
);
  logic loading, wr_en, hit;
  mac_t wr_mac, cmp_mac;

  saf_frame_parser #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_parse (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_start (ld_start),
    .ld_valid (ld_valid),
    .ld_byte  (ld_byte),
    .loading  (loading),
    .wr_en    (wr_en),
    .wr_mac   (wr_mac)
  );

  saf_addr_table #(.NUM_SLOTS(NUM_SLOTS)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (ld_start),
    .wr_en  (wr_en),
    .wr_mac (wr_mac),
    .lk_mac (cmp_mac),
    .hit    (hit)
  );

  saf_lookup_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .loading    (loading),
    .lk_req     (lk_req),
    .lk_addr    (lk_addr),
    .promisc    (promisc),
    .hit        (hit),
    .cmp_mac    (cmp_mac),
    .res_valid  (res_valid),
    .res_accept (res_accept)
  );
endmodule

// File: tb/setup_addr_filter_test.sv
`timescale 1ns/1ps
module setup_addr_filter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_start, ld_valid, lk_req, promisc;
  logic [7:0]  ld_byte;
  logic [47:0] lk_addr;
  logic        res_valid, res_accept;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  setup_addr_filter uut (
    .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_valid(ld_valid),
    .ld_byte(ld_byte), .lk_req(lk_req), .lk_addr(lk_addr), .promisc(promisc),
    .res_valid(res_valid), .res_accept(res_accept)
  );

  // ---------------- behavioural reference ----------------
  logic [47:0] m_tab[$];
  logic [7:0]  m_buf[12];
  int          m_idx;
  bit          m_loading, m_pend, m_valid, m_acc;
  logic [47:0] m_paddr;
  string       m_tag = "R1";

  function automatic bit in_tab(logic [47:0] a);
    foreach (m_tab[k]) if (m_tab[k] == a) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tab.delete();
      m_idx = 0; m_loading = 0; m_pend = 0; m_valid = 0; m_acc = 0;
      m_paddr = '0; m_tag = "R1";
    end else begin
      bit          iss;
      logic [47:0] a;
      iss = !m_loading && (lk_req || m_pend);
      a   = lk_req ? lk_addr : m_paddr;
      m_valid = iss;
      m_acc   = iss && (promisc || a[40] || in_tab(a));
      if (iss) m_tag = (!lk_req) ? "R9" : promisc ? "R5" : a[40] ? "R6" : "R7";
      else     m_tag = "R8";
      if (m_loading && lk_req) begin m_pend = 1; m_paddr = lk_addr; end
      else if (iss) m_pend = 0;
      if (ld_start) begin
        m_loading = 1; m_idx = 0; m_tab.delete();
      end else if (m_loading && ld_valid) begin
        m_buf[m_idx % 12] = ld_byte;
        if ((m_idx % 12) == 9 && !m_buf[0][0])
          m_tab.push_back({m_buf[0], m_buf[1], m_buf[4], m_buf[5], m_buf[8], m_buf[9]});
        m_idx++;
        if (m_idx == 192) m_loading = 0;
      end
    end
  end

  task automatic check(string tag, logic [47:0] got, logic [47:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Compare against the model on every cycle.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check({m_tag, " valid"}, 48'(res_valid), 48'(m_valid));
      if (m_valid) check({m_tag, " accept"}, 48'(res_accept), 48'(m_acc));
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [7:0]  frame [192];
  logic [47:0] slot_mac [16];

  task automatic build_frame(logic [7:0] fill);
    for (int s = 0; s < 16; s++) begin
      for (int o = 0; o < 12; o++) frame[s*12 + o] = fill ^ 8'(s);
      frame[s*12 + 0] = slot_mac[s][47:40];
      frame[s*12 + 1] = slot_mac[s][39:32];
      frame[s*12 + 4] = slot_mac[s][31:24];
      frame[s*12 + 5] = slot_mac[s][23:16];
      frame[s*12 + 8] = slot_mac[s][15:8];
      frame[s*12 + 9] = slot_mac[s][7:0];
    end
  endtask

  task automatic send_frame(int stop_after, logic [47:0] req_addr, int req_at);
    ld_start = 1'b1;
    @(negedge clk);
    ld_start = 1'b0;
    for (int i = 0; i < stop_after; i++) begin
      ld_valid = 1'b1;
      ld_byte  = frame[i];
      lk_req   = (i == req_at);
      lk_addr  = req_addr;
      @(negedge clk);
    end
    ld_valid = 1'b0;
    lk_req   = 1'b0;
  endtask

  task automatic lookup(logic [47:0] a, bit pm, bit exp, string tag);
    lk_req = 1'b1; lk_addr = a; promisc = pm;
    @(negedge clk);
    lk_req = 1'b0; promisc = 1'b0;
    check({tag, " valid"}, 48'(res_valid), 48'd1);
    check({tag, " accept"}, 48'(res_accept), 48'(exp));
  endtask

  localparam logic [47:0] A = 48'h02_00_00_00_00_01;
  localparam logic [47:0] B = 48'h02_00_00_00_00_03;
  localparam logic [47:0] D = 48'h02_AB_CD_00_00_05;
  localparam logic [47:0] G = 48'h02_11_22_33_44_55;

  initial begin
    rst_n = 1'b0; ld_start = 0; ld_valid = 0; ld_byte = 0;
    lk_req = 0; lk_addr = 0; promisc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset valid", 48'(res_valid), 48'd0);
    lookup(A, 0, 0, "R1");
    lookup(48'h01_00_5E_00_00_01, 0, 1, "R1");
    lookup(A, 1, 1, "R5");

    // Frame 1: slot1 and slot15 are group addresses; the rest unicast.
    slot_mac[0]  = A;
    slot_mac[1]  = 48'h03_00_00_00_00_02;
    slot_mac[2]  = B;
    for (int s = 3; s < 15; s++) slot_mac[s] = 48'h0A_00_00_00_10_00 + 48'(s);
    slot_mac[15] = 48'h01_00_5E_00_00_07;
    build_frame(8'hEE);
    frame[2] = 8'h02; frame[3] = 8'h11; frame[6] = 8'h22;
    frame[7] = 8'h33; frame[10] = 8'h44; frame[11] = 8'h55;
    send_frame(192, '0, -1);
    @(negedge clk);
    lookup(A, 0, 1, "R2");
    lookup(G, 0, 0, "R2");
    lookup(B, 0, 1, "R3");
    lookup(48'h02_00_00_00_00_02, 0, 0, "R3");
    lookup(48'h0A_00_00_00_10_0E, 0, 1, "R3");
    lookup(A ^ 48'h1000, 0, 0, "R7");
    lookup(48'h0A_00_00_00_10_0F, 0, 0, "R7");
    lookup(48'hFF_FF_FF_FF_FF_FF, 0, 1, "R6");
    lookup(48'h02_99_99_99_99_99, 1, 1, "R5");

    // R10: stray bytes outside a load leave the table alone.
    for (int i = 0; i < 20; i++) begin
      ld_valid = 1'b1; ld_byte = 8'h02 + 8'(i);
      @(negedge clk);
    end
    ld_valid = 1'b0;
    lookup(A, 0, 1, "R10");
    lookup(48'h02_03_06_07_0A_0B, 0, 0, "R10");

    // Frame 2: only D (slot 10) is unicast; a lookup of D is held mid-load.
    for (int s = 0; s < 16; s++) slot_mac[s] = 48'h01_00_00_00_00_00 + 48'(s);
    slot_mac[10] = D;
    build_frame(8'h31);
    send_frame(192, D, 100);
    check("R9 held valid", 48'(res_valid), 48'd0);
    @(negedge clk);
    check("R9 held valid", 48'(res_valid), 48'd1);
    check("R9 held accept", 48'(res_accept), 48'd1);
    @(negedge clk);
    check("R8 single pulse", 48'(res_valid), 48'd0);
    lookup(A, 0, 0, "R4");
    lookup(D, 0, 1, "R7");

    // R4: abort after 40 bytes of frame 1, then load frame 2 in full.
    slot_mac[0] = A; slot_mac[10] = 48'h01_00_00_00_00_0A;
    build_frame(8'hEE);
    send_frame(40, '0, -1);
    slot_mac[0] = 48'h01_00_00_00_00_00; slot_mac[10] = D;
    build_frame(8'h31);
    send_frame(192, '0, -1);
    @(negedge clk);
    lookup(A, 0, 0, "R4");
    lookup(D, 0, 1, "R4");
    lookup(B, 0, 0, "R4");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule